// File: doc/BRIEF.md
# Slot-Wheel Bus Arbiter with Round-Robin Reclaim

This block decides, every clock cycle, which of several bus masters may drive a shared bus. Time is cut into slots of a fixed number of cycles, and a compile-time slot map says which master owns each slot. A master that needs more bandwidth is simply given more entries in the map. While the owner of the current slot is requesting, it holds the bus, so every master has a bounded worst-case wait.

When the owner of the current slot has nothing to send, the slot is not left idle. A second-level round-robin picker gives it to one of the other requesting masters. That picker keeps a pointer that only its own grants move, so reclaimed cycles are shared fairly. The grant is a combinational one-hot vector derived from the present requests and the registered wheel and pointer state.

Top module: `slot_share_arbiter`

## Requirements
- R1: While `rst` is high, `grant` is all zeros. On the first cycle after `rst` falls, the wheel is at slot 0, cycle 0 of that slot, and the round-robin pointer is at master 0.
- R2: `grant` has at most one bit set, and that bit belongs to a master whose `req` bit is high in the same cycle.
- R3: When no `req` bit is set, `grant` is all zeros.
- R4: When the owner of the current slot has its `req` bit high, that owner is granted, whatever the other masters request.
- R5: When the slot owner is not requesting, the granted master is the first requester found by scanning master indices upward from the round-robin pointer and wrapping from N_MASTERS-1 to 0.
- R6: After a round-robin grant to master m, the pointer becomes (m+1) mod N_MASTERS in the next cycle. Owner grants and idle cycles leave the pointer unchanged.
- R7: Each slot lasts SLOT_CYCLES clock cycles. The wheel then moves to the next slot, and after slot N_SLOTS-1 it returns to slot 0.
- R8: The owner of slot k is the master index stored in bits [k*IW +: IW] of SLOT_MAP, where IW is the width of a master index. Several slots may name the same master. The default map, slots 0 to 7, is 0,1,0,2,0,1,3,2.
- R9: Whenever at least one master requests and reset is low, some master is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N_MASTERS | Per-master bus request, bit i for master i |
| grant | output | N_MASTERS | One-hot bus grant for the current cycle, zero when nobody is granted |

## Verification
The hardest corner cases are the wrap of the round-robin scan past the top index and the pointer that must ignore owner grants. A design that scans without wrapping would starve low indices when the pointer sits high. A design that moves the pointer on owner grants would hand the next reclaimed slot to the wrong master. Slot boundaries are also targeted: granting by the next slot's owner one cycle early or late shows an off-by-one slot counter. Long runs past a full turn of the wheel expose a map that does not wrap back to slot 0. A reset taken in the middle of traffic must return the pointer to master 0, or the first reclaimed grant after reset goes to the wrong master.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

    localparam int unsigned MAX_M    = 32;
    localparam int unsigned IDX_BITS = $clog2(MAX_M);

    typedef logic [MAX_M-1:0] mvec_t;

    typedef struct packed {
        logic                hit;
        logic [IDX_BITS-1:0] idx;
    } pick_t;

    // Scan n request bits upward from 'start', wrapping; return the first one set.
    function automatic pick_t first_from(input mvec_t rq, input int unsigned start,
                                         input int unsigned n);
        pick_t r;
        r.hit = 1'b0;
        r.idx = '0;
        for (int unsigned i = 0; i < MAX_M; i++) begin
            int unsigned m;
            m = (start + i) % n;
            if (i < n && !r.hit && rq[m]) begin
                r.hit = 1'b1;
                r.idx = IDX_BITS'(m);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/slot_wheel.sv
module slot_wheel
    import slot_arb_pkg::*;
#(
    parameter int unsigned N_SLOTS     = 8,
    parameter int unsigned SLOT_CYCLES = 4,
    parameter int unsigned IW          = 2,
    parameter logic [N_SLOTS*IW-1:0] SLOT_MAP = '0
) (
    input  logic          clk,
    input  logic          rst,
    output logic [IW-1:0] owner
);
    localparam int unsigned CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam int unsigned SW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
    localparam logic [CW-1:0] LAST_CYC  = CW'(SLOT_CYCLES - 1);
    localparam logic [SW-1:0] LAST_SLOT = SW'(N_SLOTS - 1);

    logic [CW-1:0] cyc_q;
    logic [SW-1:0] slot_q;
    logic [IW-1:0] tbl [N_SLOTS];

    for (genvar k = 0; k < N_SLOTS; k++) begin : g_tbl
        assign tbl[k] = SLOT_MAP[k*IW +: IW];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q  <= '0;
            slot_q <= '0;
        end else if (cyc_q == LAST_CYC) begin
            cyc_q  <= '0;
            slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    assign owner = tbl[slot_q];

    // R7
    slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_q != LAST_CYC) |=> $stable(slot_q));

    // R7
    slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_q == LAST_CYC && slot_q == LAST_SLOT) |=> (slot_q == '0));

endmodule

// File: rtl/rr_picker.sv
module rr_picker
    import slot_arb_pkg::*;
#(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cand,
    input  logic         take,
    output logic [N-1:0] pick,
    output logic         any
);
    logic [IW-1:0] ptr_q;
    logic [IW-1:0] ptr_nxt;
    mvec_t         ext;
    pick_t         p;

    always_comb begin
        ext        = '0;
        ext[N-1:0] = cand;
        p          = first_from(ext, int'(ptr_q), N);
        any        = p.hit;
        for (int i = 0; i < N; i++) begin
            pick[i] = p.hit && (p.idx == IDX_BITS'(i));
        end
        if (p.idx == IDX_BITS'(N - 1)) ptr_nxt = '0;
        else                           ptr_nxt = IW'(p.idx + 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst)              ptr_q <= '0;
        else if (take && any) ptr_q <= ptr_nxt;
    end

    // R6
    ptr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(ptr_q));

endmodule

// File: rtl/slot_share_arbiter.sv
module slot_share_arbiter
    import slot_arb_pkg::*;
#(
    parameter int unsigned N_MASTERS   = 4,
    parameter int unsigned N_SLOTS     = 8,
    parameter int unsigned SLOT_CYCLES = 4,
    parameter int unsigned IW          = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1,
    parameter logic [N_SLOTS*IW-1:0] SLOT_MAP = 16'hB484
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_MASTERS-1:0] req,
    output logic [N_MASTERS-1:0] grant
);
    logic [IW-1:0]        owner;
    logic [N_MASTERS-1:0] own_vec;
    logic [N_MASTERS-1:0] rr_pick;
    logic                 rr_any;
    logic                 owner_req;
    logic                 rr_take;

    slot_wheel #(
        .N_SLOTS    (N_SLOTS),
        .SLOT_CYCLES(SLOT_CYCLES),
        .IW         (IW),
        .SLOT_MAP   (SLOT_MAP)
    ) u_wheel (
        .clk  (clk),
        .rst  (rst),
        .owner(owner)
    );

    always_comb begin
        for (int i = 0; i < N_MASTERS; i++) begin
            own_vec[i] = (owner == IW'(i));
        end
    end

    assign owner_req = |(req & own_vec);
    assign rr_take   = !rst && !owner_req;

    rr_picker #(
        .N (N_MASTERS),
        .IW(IW)
    ) u_rr (
        .clk (clk),
        .rst (rst),
        .cand(req),
        .take(rr_take),
        .pick(rr_pick),
        .any (rr_any)
    );

    always_comb begin
        if (rst)            grant = '0;
        else if (owner_req) grant = own_vec;
        else                grant = rr_pick;
    end

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R2 R3
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);

    // R9
    no_idle_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> (|grant));

    // R4
    owner_wins_chk: assert property (@(posedge clk) disable iff (rst)
        owner_req |-> ((grant & own_vec) != '0));

endmodule

// File: tb/slot_share_arbiter_tb.sv
module slot_share_arbiter_tb;

    localparam int NM = 4;
    localparam int SC = 4;
    localparam int NS = 8;
    localparam int OWN [NS] = '{0, 1, 0, 2, 0, 1, 3, 2};

    // Directed vectors after reset: {req, expected grant}
    localparam int NV = 9;
    localparam logic [7:0] VEC [NV] = '{
        {4'b1110, 4'b0010},  // t0 slot0 owner idle, pointer 0 -> master1 (R5)
        {4'b1110, 4'b0100},  // t1 pointer moved to 2 -> master2 (R6)
        {4'b0001, 4'b0001},  // t2 owner 0 requesting (R4)
        {4'b0011, 4'b0001},  // t3 owner beats others (R4)
        {4'b1001, 4'b1000},  // t4 slot1 owner1 idle, pointer 3 -> master3 (R5 R8)
        {4'b0001, 4'b0001},  // t5 pointer wrapped to 0 -> master0 (R6)
        {4'b0000, 4'b0000},  // t6 no requests (R3)
        {4'b0101, 4'b0100},  // t7 pointer 1 scan -> master2 (R5)
        {4'b0101, 4'b0001}   // t8 slot2 owner0 now wins (R7)
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NM-1:0] req = '0;
    logic [NM-1:0] grant;

    int checks = 0;
    int errors = 0;
    int m_ptr  = 0;
    int m_t    = 0;

    always #5 clk = ~clk;

    slot_share_arbiter #(
        .N_MASTERS  (NM),
        .N_SLOTS    (NS),
        .SLOT_CYCLES(SC),
        .SLOT_MAP   (16'hB484)
    ) u_dut (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .grant(grant)
    );

    task automatic check(input logic [NM-1:0] got, input logic [NM-1:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s t=%0d grant=%b expected=%b", tag, m_t, got, exp);
        end
    endtask

    task automatic step(input logic [NM-1:0] r, input logic [NM-1:0] fixed_exp,
                        input bit use_fixed, input string tag);
        logic [NM-1:0] exp;
        int own;
        int nptr;
        @(negedge clk);
        rst = 1'b0;
        req = r;
        #1;
        own  = OWN[(m_t / SC) % NS];
        nptr = m_ptr;
        exp  = '0;
        if (r[own]) exp[own] = 1'b1;
        else begin
            for (int i = 0; i < NM; i++) begin
                int m;
                m = (m_ptr + i) % NM;
                if (exp == '0 && r[m]) begin
                    exp[m] = 1'b1;
                    nptr   = (m + 1) % NM;
                end
            end
        end
        check(grant, use_fixed ? fixed_exp : exp, tag);
        m_ptr = nptr;
        m_t++;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] lf;
        lf = 8'h5A;
        // R1: grant stays zero under reset even with all masters requesting
        repeat (2) @(negedge clk);
        req = 4'b1111;
        #1;
        check(grant, 4'b0000, "R1 reset grant");

        // Directed table walk, hand-computed expectations
        for (int v = 0; v < NV; v++) begin
            step(VEC[v][7:4], VEC[v][3:0], 1'b1, "R4/R5/R6/R7 table");
        end

        // Long pseudo-random walk across several wheel turns (R2 R3 R4 R5 R6 R7 R8 R9)
        for (int n = 0; n < 150; n++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            step(lf[3:0], '0, 1'b0, "R8 R9 wheel walk");
        end

        // R1: reset mid-traffic, then pointer back at master 0
        @(negedge clk);
        rst = 1'b1;
        req = 4'b1111;
        @(negedge clk);
        #1;
        check(grant, 4'b0000, "R1 mid-traffic reset");
        m_ptr = 0;
        m_t   = 0;
        step(4'b0110, 4'b0010, 1'b1, "R1 pointer reset");
        step(4'b0000, 4'b0000, 1'b1, "R3 idle after reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule